// File: doc/BRIEF.md
# Accumulator AND-with-memory executor

This block carries out one instruction of a small single-accumulator processor: the accumulator is combined bit by bit with a 16-bit word in memory, and the AND replaces the accumulator. The dispatcher pulses `start` with the instruction's address on `iar`. The block then reads the instruction words through a synchronous read port that returns data one cycle after the request. It forms the effective address, follows an optional indirect pointer, reads the operand, and in a single cycle writes the new accumulator value and the next instruction address.

The first instruction word has a format bit in bit 10 (1 = two-word form), a base-register tag in bits 9:8, and an 8-bit field in bits 7:0. Bits 15:11 hold the opcode, which the dispatcher has already matched, so this block does not examine them. In the one-word form the field is a signed displacement. It is added to the address of the next instruction (tag 0) or to one of three index registers (tags 1 to 3). In the two-word form the second word is a full address, and tags 1 to 3 add an index register to it. Bit 7 then asks for one indirect hop through memory. Every form is legal. All address arithmetic wraps modulo 2^16. The block has no memory write path and no indicator outputs, so memory contents and the carry and overflow flags are never changed.

Top module: `mem_and_exec`

## Requirements
- R1: In the done cycle, `acc_wr_en` is 1 and `acc_wr_data` equals `acc_in` AND the operand word, with each bit position combined only with the same position.
- R2: One-word form (bit 10 = 0), tag 0: the effective address is (instruction address + 1) + sign-extended bits 7:0, modulo 2^16.
- R3: One-word form, tag n in 1..3: the effective address is index register n (`xr1`/`xr2`/`xr3`) + sign-extended bits 7:0, modulo 2^16.
- R4: Two-word form (bit 10 = 1) with bit 7 = 0: the effective address is the second word for tag 0, and the second word + index register n for tag n in 1..3.
- R5: Two-word form with bit 7 = 1: the address formed as in R4 is read, and the word found there becomes the effective address.
- R6: In the done cycle, `iar_wr_en` is 1 and `iar_wr_data` is the latched instruction address + 1 (one-word form) or + 2 (two-word form). The instruction address is taken from `iar` in the cycle `start` is accepted.
- R7: `done` is a one-cycle pulse that comes 2 cycles after the accepting edge for the one-word form, 3 for the direct two-word form and 4 for the indirect two-word form.
- R8: Bits 15:11 of the first word, and in the two-word form bits 6:0, have no effect on the result.
- R9: `start` is ignored while an instruction is in progress.
- R10: When idle and `start` is low, `mem_rd_en` is 0. Outside the done cycle, `done`, `acc_wr_en` and `iar_wr_en` are 0, and all three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing the instruction at `iar` |
| iar | input | 16 | Address of the instruction's first word |
| xr1 | input | 16 | Index register 1 |
| xr2 | input | 16 | Index register 2 |
| xr3 | input | 16 | Index register 3 |
| acc_in | input | 16 | Current accumulator value |
| mem_rd_data | input | 16 | Read data, valid the cycle after a request |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_data | output | 16 | New accumulator value |
| iar_wr_en | output | 1 | Instruction address write strobe |
| iar_wr_data | output | 16 | Address of the next instruction |
| done | output | 1 | Instruction complete |

## Verification
All results arrive in the done cycle. That cycle comes 2, 3 or 4 clock edges after `start` is accepted, depending on whether the instruction is one-word, two-word direct or two-word indirect. The bench drives `start` on a falling edge and counts falling edges until `done` appears. It compares that count with the expected latency for the format, and samples the accumulator and instruction-address outputs at that same falling edge. On the next falling edge it confirms that the block is idle and silent. The memory model registers each read on the rising edge, which gives the one-cycle latency the design assumes.

// File: rtl/mand_pkg.sv
package mand_pkg;
   localparam int unsigned TAG_W    = 2;
   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned WORD_MIN = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEC,
      ST_ADR,
      ST_IND,
      ST_WB
   } mand_state_t;

   typedef struct packed {
      logic               is_long;
      logic [TAG_W-1:0]   tag;
      logic               indir;
      logic [FIELD_W-1:0] field;
   } mand_fmt_t;

   function automatic mand_fmt_t mand_split(input logic [WORD_MIN-1:0] w);
      mand_fmt_t f;
      f.is_long = w[10];
      f.tag     = w[9:8];
      f.indir   = w[10] & w[7];
      f.field   = w[7:0];
      return f;
   endfunction
endpackage

// File: rtl/mand_dext.sv
module mand_dext #(
   parameter int unsigned W        = 16,
   parameter int unsigned FW       = 8,
   parameter bit          SIGN_EXT = 1'b1
) (
   input  logic [FW-1:0] fld,
   output logic [W-1:0]  ext
);
   if (W <= FW) begin : g_bad_width
      $error("mand_dext: W must exceed FW");
   end

   if (SIGN_EXT) begin : g_sext
      assign ext = {{(W-FW){fld[FW-1]}}, fld};
   end else begin : g_zext
      assign ext = {{(W-FW){1'b0}}, fld};
   end
endmodule

// File: rtl/mand_xsel.sv
module mand_xsel #(
   parameter int unsigned W     = 16,
   parameter int unsigned TAG_W = 2
) (
   input  logic [((1<<TAG_W)-1)*W-1:0] xr_flat,
   input  logic [TAG_W-1:0]            tag,
   input  logic                        is_long,
   input  logic [W-1:0]                next_ia,
   output logic [W-1:0]                base
);
   localparam int unsigned NXR = (1 << TAG_W) - 1;

   logic [W-1:0] bases [0:NXR];

   assign bases[0] = is_long ? '0 : next_ia;

   for (genvar k = 1; k <= NXR; k++) begin : g_xr
      assign bases[k] = xr_flat[k*W-1 -: W];
   end

   assign base = bases[tag];
endmodule

// File: rtl/mand_agen.sv
module mand_agen #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] off,
   output logic [W-1:0] ea
);
   assign ea = base + off;
endmodule

// File: rtl/mand_seq.sv
module mand_seq
   import mand_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] iar,
   input  logic [W-1:0] rd_data,
   input  logic [W-1:0] ea,
   input  logic         long_now,
   input  logic         long_q,
   input  logic         ind_q,
   output mand_state_t  state_q,
   output logic [W-1:0] ia_inc1,
   output logic         rd_en,
   output logic [W-1:0] rd_addr,
   output logic [W-1:0] next_ia,
   output logic         fin
);
   mand_state_t  state_d;
   logic [W-1:0] ia_q;
   logic [W-1:0] ia_inc2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ia_q    <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) ia_q <= iar;
      end
   end

   always_comb begin
      state_d = state_q;
      rd_en   = 1'b0;
      rd_addr = '0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               rd_en   = 1'b1;
               rd_addr = iar;
               state_d = ST_DEC;
            end
         end
         ST_DEC: begin
            rd_en = 1'b1;
            if (long_now) begin
               rd_addr = ia_inc1;
               state_d = ST_ADR;
            end else begin
               rd_addr = ea;
               state_d = ST_WB;
            end
         end
         ST_ADR: begin
            rd_en   = 1'b1;
            rd_addr = ea;
            state_d = ind_q ? ST_IND : ST_WB;
         end
         ST_IND: begin
            rd_en   = 1'b1;
            rd_addr = rd_data;
            state_d = ST_WB;
         end
         ST_WB:   state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign ia_inc1 = ia_q + W'(1);
   assign ia_inc2 = ia_q + W'(2);
   assign next_ia = long_q ? ia_inc2 : ia_inc1;
   assign fin     = (state_q == ST_WB);
endmodule

// File: rtl/mem_and_exec.sv
module mem_and_exec
   import mand_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter bit          SIGN_DISP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] iar,
   input  logic [W-1:0] xr1,
   input  logic [W-1:0] xr2,
   input  logic [W-1:0] xr3,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] mem_rd_data,
   output logic         mem_rd_en,
   output logic [W-1:0] mem_rd_addr,
   output logic         acc_wr_en,
   output logic [W-1:0] acc_wr_data,
   output logic         iar_wr_en,
   output logic [W-1:0] iar_wr_data,
   output logic         done
);
   localparam int unsigned NXR = (1 << TAG_W) - 1;

   if (W != WORD_MIN) begin : g_bad_w
      $error("mem_and_exec: word width must be 16");
   end
   if (NXR != 3) begin : g_bad_nxr
      $error("mem_and_exec: three index registers expected");
   end

   mand_state_t  state_q;
   mand_fmt_t    fmt_q;
   mand_fmt_t    fmt_now;
   logic [W-1:0] disp_ext;
   logic [W-1:0] off;
   logic [W-1:0] base;
   logic [W-1:0] ea;
   logic [W-1:0] ia_inc1;
   logic         fin;

   assign fmt_now = (state_q == ST_DEC) ? mand_split(mem_rd_data[WORD_MIN-1:0]) : fmt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  fmt_q <= '0;
      else if (state_q == ST_DEC)  fmt_q <= fmt_now;
   end

   mand_dext #(.W(W), .FW(FIELD_W), .SIGN_EXT(SIGN_DISP)) u_dext (
      .fld (fmt_now.field),
      .ext (disp_ext)
   );

   assign off = (state_q == ST_DEC) ? disp_ext : mem_rd_data;

   mand_xsel #(.W(W), .TAG_W(TAG_W)) u_xsel (
      .xr_flat (({xr3, xr2, xr1})),
      .tag     (fmt_now.tag),
      .is_long (fmt_now.is_long),
      .next_ia (ia_inc1),
      .base    (base)
   );

   mand_agen #(.W(W)) u_agen (
      .base (base),
      .off  (off),
      .ea   (ea)
   );

   mand_seq #(.W(W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .iar      (iar),
      .rd_data  (mem_rd_data),
      .ea       (ea),
      .long_now (fmt_now.is_long),
      .long_q   (fmt_q.is_long),
      .ind_q    (fmt_q.indir),
      .state_q  (state_q),
      .ia_inc1  (ia_inc1),
      .rd_en    (mem_rd_en),
      .rd_addr  (mem_rd_addr),
      .next_ia  (iar_wr_data),
      .fin      (fin)
   );

   assign acc_wr_data = acc_in & mem_rd_data;
   assign acc_wr_en   = fin;
   assign iar_wr_en   = fin;
   assign done        = fin;
endmodule

// File: rtl/mand_chk.sv
module mand_chk
   import mand_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         done,
   input logic         mem_rd_en,
   input logic [W-1:0] mem_rd_data,
   input logic [W-1:0] acc_in,
   input logic [W-1:0] acc_wr_data,
   input logic         acc_wr_en,
   input logic         iar_wr_en,
   input mand_state_t  state_q
);
   assert_and_no_extra_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((acc_wr_data & ~acc_in) == '0));

   assert_and_no_extra_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((acc_wr_data & ~mem_rd_data) == '0));

   assert_write_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr_en |-> iar_wr_en);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_read_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd_en);

   assert_back_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state_q == ST_IDLE));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !start) |-> !mem_rd_en);
endmodule

bind mem_and_exec mand_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .done        (done),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_data (mem_rd_data),
   .acc_in      (acc_in),
   .acc_wr_data (acc_wr_data),
   .acc_wr_en   (acc_wr_en),
   .iar_wr_en   (iar_wr_en),
   .state_q     (state_q)
);

// File: tb/sim_mem_and_exec.sv
`timescale 1ns/1ps
module sim_mem_and_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] iar = '0;
   logic [15:0] xr_v [0:3];
   logic [15:0] acc_in = '0;
   logic [15:0] mem_rd_data = '0;
   logic        mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic        acc_wr_en;
   logic [15:0] acc_wr_data;
   logic        iar_wr_en;
   logic [15:0] iar_wr_data;
   logic        done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [15:0] t_ia = '0, t_w1 = '0, t_w2 = '0, t_ptr_at = '0, t_ptr = '0;
   bit          t_long = 1'b0, t_ind = 1'b0;

   always #4 clk = ~clk;

   mem_and_exec u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .iar(iar),
      .xr1(xr_v[1]), .xr2(xr_v[2]), .xr3(xr_v[3]), .acc_in(acc_in),
      .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
      .iar_wr_en(iar_wr_en), .iar_wr_data(iar_wr_data), .done(done)
   );

   function automatic logic [15:0] memval(input logic [15:0] a);
      if (a == t_ia)                          return t_w1;
      else if (t_long && a == t_ia + 16'd1)   return t_w2;
      else if (t_ind && a == t_ptr_at)        return t_ptr;
      else                                    return (a * 16'h9E37) ^ 16'h3C5A;
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= memval(mem_rd_addr);

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         summary();
      end
   end

   // Run one instruction; expected values derived from the requirements.
   task automatic run(input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] ia,
                      input logic [15:0] ptr, input logic [15:0] acc, input bit extra_start,
                      input string req);
      logic [15:0] ea, pat, exp_acc, exp_iar, xsel;
      logic [1:0]  tag;
      int          lat, n;
      bit          seen;
      tag    = w1[9:8];
      xsel   = (tag == 2'd0) ? 16'h0000 : xr_v[tag];
      t_ia   = ia; t_w1 = w1; t_w2 = w2; t_ptr = ptr;
      t_long = w1[10];
      t_ind  = w1[10] & w1[7];
      if (!t_long) begin
         ea      = ((tag == 2'd0) ? ia + 16'd1 : xsel) + {{8{w1[7]}}, w1[7:0]};
         lat     = 2;
         exp_iar = ia + 16'd1;
      end else begin
         pat      = w2 + xsel;
         t_ptr_at = pat;
         ea       = t_ind ? memval(pat) : pat;
         lat      = t_ind ? 4 : 3;
         exp_iar  = ia + 16'd2;
      end
      exp_acc = acc & memval(ea);
      acc_in = acc; iar = ia; start = 1'b1;
      @(negedge clk);
      start = extra_start; iar = ~ia; n = 1; seen = 1'b0;
      while (!seen && n < 12) begin
         if (done) seen = 1'b1;
         else begin
            @(negedge clk);
            start = 1'b0;
            n++;
         end
      end
      chk("R7", "latency", 16'(n), 16'(lat));
      chk(req, "acc_wr_data", acc_wr_data, exp_acc);
      chk("R1", "acc_wr_en", 16'(acc_wr_en), 16'd1);
      chk("R6", "iar_wr_data", iar_wr_data, exp_iar);
      chk("R6", "iar_wr_en", 16'(iar_wr_en), 16'd1);
      @(negedge clk);
      chk("R7", "done pulse end", 16'(done), 16'd0);
      chk("R10", "idle read", 16'(mem_rd_en), 16'd0);
      chk("R10", "idle acc_wr_en", 16'(acc_wr_en), 16'd0);
   endtask

   initial begin
      xr_v[0] = 16'h0000; xr_v[1] = 16'h0005; xr_v[2] = 16'h7FF0; xr_v[3] = 16'hFFF8;
      repeat (3) @(negedge clk);
      chk("R10", "reset done", 16'(done), 16'd0);
      chk("R10", "reset rd_en", 16'(mem_rd_en), 16'd0);
      chk("R10", "reset acc_wr_en", 16'(acc_wr_en), 16'd0);
      chk("R10", "reset iar_wr_en", 16'(iar_wr_en), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle no start", 16'(mem_rd_en), 16'd0);

      // R2: one-word, tag 0, every displacement, addresses near the top to wrap
      for (int d = 0; d < 256; d++)
         run({5'b11100, 1'b0, 2'd0, 8'(d)}, 16'h0000, 16'hFF80 + 16'(d * 3),
             16'h0000, 16'hFFFF ^ 16'(d << 5), 1'b0, "R2");

      // R3: one-word, index tags, every displacement
      for (int t = 1; t < 4; t++)
         for (int d = 0; d < 256; d++)
            run({5'b11100, 1'b0, 2'(t), 8'(d)}, 16'h0000, 16'h1200 + 16'(d),
                16'h0000, 16'hA5F0 ^ 16'(d * 77), 1'b0, "R3");

      // R4 and R8: two-word direct, junk in bits 6:0 and in the opcode bits
      for (int t = 0; t < 4; t++)
         for (int k = 0; k < 16; k++)
            run({(k[0] ? 5'b11100 : 5'(k + 3)), 1'b1, 2'(t), 1'b0, 7'(k * 9)},
                16'hFFF0 + 16'(k * 4099), 16'h3000 + 16'(k * 8),
                16'h0000, 16'h0F0F ^ 16'(k * 4369), 1'b0, k[0] ? "R4" : "R8");

      // R5: two-word indirect
      for (int t = 0; t < 4; t++)
         for (int k = 0; k < 16; k++)
            run({5'b11100, 1'b1, 2'(t), 1'b1, 7'(k * 13)},
                16'h8000 + 16'(k * 911), 16'h4100 + 16'(k * 8),
                16'h6000 + 16'(k * 257), 16'hFFFF ^ 16'(1 << k), 1'b0, "R5");

      // R9: second start while busy, for each format
      run({5'b11100, 1'b0, 2'd1, 8'h80}, 16'h0000, 16'h2000, 16'h0000, 16'hFFFF, 1'b1, "R9");
      run({5'b11100, 1'b1, 2'd2, 8'h00}, 16'h0123, 16'h2100, 16'h0000, 16'hF00F, 1'b1, "R9");
      run({5'b11100, 1'b1, 2'd3, 8'h80}, 16'h0456, 16'h2200, 16'h5555, 16'h7E7E, 1'b1, "R9");

      summary();
   end
endmodule